// File: doc/BRIEF.md
# Descriptor-Driven Memory Transfer Engine

This block runs one transfer cycle for a single channel from a four-word descriptor in memory. A start pulse gives it the descriptor address. The engine fetches the first three words of the descriptor: the source end pointer, the destination end pointer and a packed control word. It checks the operating mode and then moves the counted number of items. Each item is a read from the source followed by a write to the destination, over a simple request/acknowledge bus.

The engine does not walk addresses forward from a start address. It works them out from the end pointers and from the remaining-count field. The first item is therefore the lowest address, and the last item lands exactly on the end pointer. When the cycle ends, the engine writes the control word back with the mode and count fields cleared and pulses `done`. A bad mode code or a bus error pulses `error` instead. In auto-request mode the whole cycle runs from the start pulse alone. In basic mode each block of items waits for a peripheral request.

Top module: `dma_desc_engine`

## Requirements
- R1: After `start`, the engine reads three words (size code 2) at `desc_base`, `desc_base+4` and `desc_base+8`, in that order. The words are taken as the source end pointer, the destination end pointer and the control word.
- R2: Control word fields, from bit 0 upward:
  - mode [2:0]
  - chaining flag [3]
  - count-minus-one [13:4]
  - block exponent [17:14]
  - two 3-bit protection fields [23:18]
  - source size [25:24]
  - source step [27:26]
  - destination size [29:28]
  - destination step [31:30]
- R3: One cycle moves count-minus-one plus one items, from 1 to 1024.
- R4: For an item with remaining count r (count-minus-one for the first item, falling by one per item), the address is end − (r << step). Step code 0 is byte, 1 halfword and 2 word. Step code 3 keeps the address equal to the end pointer.
- R5: Each item is one read at the source address with the source size code, then one write at the destination address with the destination size code. The write carries the data just read. Size code 0 is byte, 1 halfword and 2 word.
- R6: After the last item, the engine writes the control word back to `desc_base+8` (size 2) with bits [13:0] except bit 3 cleared, so that mode becomes 0 and count-minus-one becomes 0. It then pulses `done` for one cycle.
- R7: Mode 2 (auto-request) runs every item without looking at `dreq`.
- R8: Mode 1 (basic) waits for `dreq` high before each block of 2^exponent items. Exponents of 10 and above mean 1024.
- R9: Any mode code other than 1 or 2 pulses `error`. No item is moved and no writeback is made.
- R10: An acknowledge with `bus_err` high pulses `error`. No further bus request follows, and `done` does not pulse.
- R11: A request holds `bus_addr`, `bus_we` and `bus_wdata` steady until it is acknowledged.
- R12: After reset, `busy`, `done`, `error` and `bus_req` are low. No request is made while not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that launches a cycle when idle |
| desc_base | input | AW | Descriptor address |
| dreq | input | 1 | Peripheral request for the next block (basic mode) |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-cycle pulse on completion |
| error | output | 1 | One-cycle pulse on bad mode or bus error |
| bus_req | output | 1 | Bus request |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | AW | Byte address |
| bus_size | output | 2 | Size code of the access |
| bus_wdata | output | DW | Write data |
| bus_ack | input | 1 | Access complete |
| bus_err | input | 1 | Access failed (valid with ack) |
| bus_rdata | input | DW | Read data (valid with ack) |

## Verification
The scoreboard predicts every bus beat, covering fetch, item reads and writes, and the writeback, so any mismatch is caught at the beat where it happens.

| Corner case | What a wrong design would do |
|---|---|
| Single-item and 1024-item cycles | An off-by-one count moves one item too many or too few, or wraps the count to zero. |
| Step code 3 | A design that applies the shift anyway walks a peripheral address it should hold. |
| Mixed sizes and steps | A swapped field decode shows up as a wrong size code or a wrong address. |
| Basic mode stalls between blocks | A design that ignores the block exponent either runs straight through or stalls after every item. |
| Bad mode codes, and bus errors during fetch and during an item | A faulty design goes on to move data or writes a stale writeback. |

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

    localparam int CNT_W  = 10;
    localparam int WORD_W = 32;

    localparam logic [2:0] MODE_BASIC = 3'd1;
    localparam logic [2:0] MODE_AUTO  = 3'd2;

    localparam logic [1:0] STEP_NONE = 2'd3;
    localparam logic [1:0] SIZE_WORD = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_WAIT,
        ST_RD,
        ST_WR,
        ST_WB
    } eng_state_e;

    typedef struct packed {
        logic             mode_ok;
        logic             basic;
        logic [CNT_W-1:0] nm1;
        logic [CNT_W-1:0] blk_mask;
        logic [1:0]       src_size;
        logic [1:0]       src_step;
        logic [1:0]       dst_size;
        logic [1:0]       dst_step;
        logic [WORD_W-1:0] wb_word;
    } ctrl_dec_t;

endpackage

// File: rtl/dma_ctrl_decode.sv
module dma_ctrl_decode
    import dma_eng_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output ctrl_dec_t         dec
);
    logic [2:0] mode;
    logic [3:0] expo;

    always_comb begin
        mode         = word[2:0];
        expo         = word[17:14];
        dec.mode_ok  = (mode == MODE_BASIC) || (mode == MODE_AUTO);
        dec.basic    = (mode == MODE_BASIC);
        dec.nm1      = word[13:4];
        // exponents >= CNT_W saturate to a full-count block
        dec.blk_mask = ~({CNT_W{1'b1}} << expo);
        dec.src_size = word[25:24];
        dec.src_step = word[27:26];
        dec.dst_size = word[29:28];
        dec.dst_step = word[31:30];
        dec.wb_word  = {word[31:14], {CNT_W{1'b0}}, word[3], 3'b000};
    end
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dma_eng_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0]    end_ptr,
    input  logic [CNT_W-1:0] remain,
    input  logic [1:0]       step,
    output logic [AW-1:0]    addr
);
    logic [AW-1:0] offset;

    always_comb begin
        unique case (step)
            2'd0:    offset = AW'(remain);
            2'd1:    offset = AW'({remain, 1'b0});
            2'd2:    offset = AW'({remain, 2'b00});
            default: offset = '0;
        endcase
        addr = end_ptr - offset;
    end
endmodule

// File: rtl/dma_desc_engine.sv
module dma_desc_engine
    import dma_eng_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] desc_base,
    input  logic          dreq,
    output logic          busy,
    output logic          done,
    output logic          error,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [1:0]    bus_size,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_ack,
    input  logic          bus_err,
    input  logic [DW-1:0] bus_rdata
);
    localparam logic [AW-1:0] CTRL_OFS = AW'(8);

    typedef struct packed {
        eng_state_e        st;
        logic [1:0]        fidx;
        logic [AW-1:0]     base;
        logic [AW-1:0]     src_end;
        logic [AW-1:0]     dst_end;
        logic [WORD_W-1:0] ctrl;
        logic [CNT_W-1:0]  remain;
        logic [CNT_W-1:0]  blk;
        logic [DW-1:0]     data;
        logic              done;
        logic              err;
    } eng_regs_t;

    eng_regs_t r_q, r_d;
    ctrl_dec_t dec;
    logic [AW-1:0] src_addr, dst_addr;

    dma_ctrl_decode u_dec (
        .word (r_q.ctrl),
        .dec  (dec)
    );

    dma_addr_gen #(.AW(AW)) u_src_addr (
        .end_ptr (r_q.src_end),
        .remain  (r_q.remain),
        .step    (dec.src_step),
        .addr    (src_addr)
    );

    dma_addr_gen #(.AW(AW)) u_dst_addr (
        .end_ptr (r_q.dst_end),
        .remain  (r_q.remain),
        .step    (dec.dst_step),
        .addr    (dst_addr)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.base = desc_base;
                    r_d.fidx = 2'd0;
                    r_d.st   = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (bus_ack) begin
                    if (bus_err) begin
                        r_d.err = 1'b1;
                        r_d.st  = ST_IDLE;
                    end else begin
                        unique case (r_q.fidx)
                            2'd0:    r_d.src_end = bus_rdata[AW-1:0];
                            2'd1:    r_d.dst_end = bus_rdata[AW-1:0];
                            default: r_d.ctrl    = bus_rdata[WORD_W-1:0];
                        endcase
                        if (r_q.fidx == 2'd2) r_d.st = ST_CHECK;
                        else                  r_d.fidx = r_q.fidx + 2'd1;
                    end
                end
            end
            ST_CHECK: begin
                if (!dec.mode_ok) begin
                    r_d.err = 1'b1;
                    r_d.st  = ST_IDLE;
                end else begin
                    r_d.remain = dec.nm1;
                    r_d.blk    = '0;
                    r_d.st     = dec.basic ? ST_WAIT : ST_RD;
                end
            end
            ST_WAIT: begin
                if (dreq) r_d.st = ST_RD;
            end
            ST_RD: begin
                if (bus_ack) begin
                    if (bus_err) begin
                        r_d.err = 1'b1;
                        r_d.st  = ST_IDLE;
                    end else begin
                        r_d.data = bus_rdata;
                        r_d.st   = ST_WR;
                    end
                end
            end
            ST_WR: begin
                if (bus_ack) begin
                    if (bus_err) begin
                        r_d.err = 1'b1;
                        r_d.st  = ST_IDLE;
                    end else if (r_q.remain == '0) begin
                        r_d.st = ST_WB;
                    end else begin
                        r_d.remain = r_q.remain - 1'b1;
                        if (dec.basic && (r_q.blk == dec.blk_mask)) begin
                            r_d.blk = '0;
                            r_d.st  = ST_WAIT;
                        end else begin
                            r_d.blk = r_q.blk + 1'b1;
                            r_d.st  = ST_RD;
                        end
                    end
                end
            end
            ST_WB: begin
                if (bus_ack) begin
                    r_d.st = ST_IDLE;
                    if (bus_err) r_d.err  = 1'b1;
                    else         r_d.done = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_size  = SIZE_WORD;
        bus_wdata = '0;
        unique case (r_q.st)
            ST_FETCH: begin
                bus_req  = 1'b1;
                bus_addr = r_q.base + AW'({r_q.fidx, 2'b00});
            end
            ST_RD: begin
                bus_req  = 1'b1;
                bus_addr = src_addr;
                bus_size = dec.src_size;
            end
            ST_WR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = dst_addr;
                bus_size  = dec.dst_size;
                bus_wdata = r_q.data;
            end
            ST_WB: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = r_q.base + CTRL_OFS;
                bus_wdata = DW'(dec.wb_word);
            end
            default: ;
        endcase
    end

    assign busy  = (r_q.st != ST_IDLE);
    assign done  = r_q.done;
    assign error = r_q.err;

endmodule

// File: rtl/dma_desc_engine_chk.sv
module dma_desc_engine_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          error,
    input logic          bus_req,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          bus_ack,
    input logic          bus_err
);
    a_r11_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

    a_r12_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req);

    a_r6_done_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bus_req && bus_we && bus_ack && !bus_err));

    a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_no_done_with_err: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    a_r10_err_ends_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> !busy);
endmodule

bind dma_desc_engine dma_desc_engine_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .error     (error),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack),
    .bus_err   (bus_err)
);

// File: tb/tb_dma_desc_engine.sv
`timescale 1ns/1ps
module tb_dma_desc_engine;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] desc_base = '0;
    logic          dreq = 1'b0;
    logic          busy, done, error;
    logic          bus_req, bus_we;
    logic [AW-1:0] bus_addr;
    logic [1:0]    bus_size;
    logic [DW-1:0] bus_wdata;
    logic          bus_ack = 1'b0;
    logic          bus_err = 1'b0;
    logic [DW-1:0] bus_rdata = '0;

    always #2 clk = ~clk;

    dma_desc_engine #(.AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .desc_base(desc_base), .dreq(dreq),
        .busy(busy), .done(done), .error(error),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata)
    );

    typedef struct {
        logic          we;
        logic [AW-1:0] addr;
        logic [1:0]    size;
        logic [DW-1:0] data;
        string         tag;
    } beat_t;

    beat_t exp_q[$];
    int checks = 0;
    int errors = 0;
    int beat_no = 0;
    int err_beat = -1;
    int done_cnt = 0;
    int err_cnt = 0;
    int cycles = 0;
    logic [AW-1:0] cur_base, cur_se, cur_de;
    logic [31:0]   cur_ctrl;

    function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
        if (a == cur_base)            return cur_se;
        if (a == cur_base + 32'd4)    return cur_de;
        if (a == cur_base + 32'd8)    return cur_ctrl;
        if (a == cur_base + 32'd12)   return '0;
        return {a[15:0], ~a[15:0]};
    endfunction

    // R2 field positions
    function automatic logic [31:0] mk_ctrl(input int mode, input int nm1, input int expo,
                                            input int ss, input int sst, input int ds, input int dst);
        logic [31:0] w;
        w = '0;
        w[2:0]   = mode[2:0];
        w[3]     = 1'b1;
        w[13:4]  = nm1[9:0];
        w[17:14] = expo[3:0];
        w[23:18] = 6'b101101;
        w[25:24] = ss[1:0];
        w[27:26] = sst[1:0];
        w[29:28] = ds[1:0];
        w[31:30] = dst[1:0];
        return w;
    endfunction

    function automatic logic [AW-1:0] item_addr(input logic [AW-1:0] e, input int r, input logic [1:0] st);
        if (st == 2'd3) return e;
        return e - (AW'(r) << st);
    endfunction

    task automatic push(input logic we, input logic [AW-1:0] a, input logic [1:0] sz,
                        input logic [DW-1:0] d, input string tag);
        beat_t b;
        b.we = we; b.addr = a; b.size = sz; b.data = d; b.tag = tag;
        exp_q.push_back(b);
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // responder and scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (done)  done_cnt++;
            if (error) err_cnt++;
            if (bus_ack) begin
                bus_ack = 1'b0;
                bus_err = 1'b0;
            end else if (bus_req) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10", "unexpected beat addr", longint'(bus_addr), 0);
                end else begin
                    beat_t e;
                    e = exp_q.pop_front();
                    check(bus_we == e.we && bus_addr == e.addr && bus_size == e.size &&
                          (!e.we || bus_wdata == e.data), e.tag,
                          $sformatf("beat %0d we/addr/size/data", beat_no),
                          {bus_we, bus_size, bus_addr, bus_wdata[27:0]},
                          {e.we, e.size, e.addr, e.data[27:0]});
                end
                bus_rdata = mem_val(bus_addr);
                bus_err   = (beat_no == err_beat);
                bus_ack   = 1'b1;
                beat_no++;
            end
        end
    end

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%0d expected<150000", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    task automatic launch(input logic [AW-1:0] base, input logic [AW-1:0] se, input logic [AW-1:0] de,
                          input logic [31:0] ctrl, input int ebeat, input bit expect_run);
        logic [31:0] wb;
        int n;
        int k;
        int total;
        cur_base = base; cur_se = se; cur_de = de; cur_ctrl = ctrl;
        err_beat = ebeat;
        beat_no  = 0;
        exp_q.delete();
        total = 0;
        // R1 descriptor fetch order
        for (int i = 0; i < 3; i++) begin
            if (ebeat < 0 || total <= ebeat) push(1'b0, base + AW'(4*i), 2'd2, '0, "R1");
            total++;
        end
        if (expect_run) begin
            n = int'(ctrl[13:4]) + 1;                       // R3
            for (k = 0; k < n; k++) begin
                logic [AW-1:0] ra, wa;
                int r;
                r  = n - 1 - k;
                ra = item_addr(se, r, ctrl[27:26]);         // R4
                wa = item_addr(de, r, ctrl[31:30]);
                if (ebeat < 0 || total <= ebeat) push(1'b0, ra, ctrl[25:24], '0, "R4");
                total++;
                if (ebeat < 0 || total <= ebeat) push(1'b1, wa, ctrl[29:28], mem_val(ra), "R5");
                total++;
            end
            wb = ctrl & ~32'h0000_3FF7;                     // R6
            if (ebeat < 0 || total <= ebeat) push(1'b1, base + 32'd8, 2'd2, wb, "R6");
        end
        @(negedge clk);
        desc_base = base;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_cycle(input bit expect_err, input string tag);
        int d0, e0, t;
        d0 = done_cnt; e0 = err_cnt; t = 0;
        while (done_cnt == d0 && err_cnt == e0 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        repeat (6) @(negedge clk);
        check((done_cnt - d0) == (expect_err ? 0 : 1) && (err_cnt - e0) == (expect_err ? 1 : 0),
              tag, "done/error pulses", (done_cnt - d0) * 16 + (err_cnt - e0),
              expect_err ? 1 : 16);
        check(exp_q.size() == 0, tag, "missing beats", exp_q.size(), 0);
        check(!busy && !bus_req, tag, "idle after cycle", {busy, bus_req}, 0);
        err_beat = -1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        check(!busy && !done && !error && !bus_req, "R12", "reset outputs",
              {busy, done, error, bus_req}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R7 auto, 4 items, word steps, word sizes
        launch(32'h100, 32'h2000, 32'h3000, mk_ctrl(2, 3, 0, 2, 2, 2, 2), -1, 1);
        finish_cycle(0, "R7");

        // R3 single item
        launch(32'h140, 32'h2100, 32'h3100, mk_ctrl(2, 0, 0, 2, 2, 2, 2), -1, 1);
        finish_cycle(0, "R3");

        // R4 byte source steps, fixed destination, mixed sizes
        launch(32'h180, 32'h4007, 32'h5000, mk_ctrl(2, 5, 0, 0, 0, 1, 3), -1, 1);
        finish_cycle(0, "R4");

        // R5 halfword steps both sides
        launch(32'h1C0, 32'h600E, 32'h7002, mk_ctrl(2, 3, 2, 1, 1, 1, 1), -1, 1);
        finish_cycle(0, "R5");

        // R8 basic mode, 6 items in blocks of 2
        launch(32'h200, 32'h8000, 32'h9000, mk_ctrl(1, 5, 1, 2, 2, 2, 2), -1, 1);
        for (int blk = 0; blk < 3; blk++) begin
            repeat (30) @(negedge clk);
            check(beat_no == 3 + 4*blk, "R8", "stall before block", beat_no, 3 + 4*blk);
            dreq = 1'b1;
            @(negedge clk);
            dreq = 1'b0;
        end
        finish_cycle(0, "R8");

        // R9 invalid modes
        launch(32'h240, 32'h2000, 32'h3000, mk_ctrl(0, 3, 0, 2, 2, 2, 2), -1, 0);
        finish_cycle(1, "R9");
        launch(32'h240, 32'h2000, 32'h3000, mk_ctrl(5, 3, 0, 2, 2, 2, 2), -1, 0);
        finish_cycle(1, "R9");
        launch(32'h240, 32'h2000, 32'h3000, mk_ctrl(7, 3, 0, 2, 2, 2, 2), -1, 0);
        finish_cycle(1, "R9");

        // R10 bus errors: during first item read, during fetch
        launch(32'h280, 32'h2000, 32'h3000, mk_ctrl(2, 3, 0, 2, 2, 2, 2), 3, 1);
        finish_cycle(1, "R10");
        launch(32'h280, 32'h2000, 32'h3000, mk_ctrl(2, 3, 0, 2, 2, 2, 2), 1, 1);
        finish_cycle(1, "R10");

        // R3 maximum count, 1024 items
        launch(32'h300, 32'h0001_1000, 32'h0002_2000, mk_ctrl(2, 1023, 0, 2, 2, 2, 2), -1, 1);
        finish_cycle(0, "R3");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule